// File: doc/BRIEF.md
# 1-Wire ROM search step unit

This block performs a single step of the 1-Wire ROM search. When it accepts a start request, it asks an external slot engine for two read slots. The first read returns the id bit and the second returns its complement. From the two bits it picks the branch to follow. It then asks the engine for one write slot that sends the chosen branch bit back onto the bus. The caller gives a preferred branch with the start request. The block returns a 3-bit status once the step is finished.

The slot engine is driven through a one-cycle request pulse and a slot kind code. The engine answers each request with a one-cycle acknowledge. For a read slot, the sampled bus level is presented with that acknowledge. When neither the id bit nor the complement bit is pulled low, no device is responding. The step then ends with an error code and without a write slot, and the caller restarts the search. The outer search loop, the discrepancy bookkeeping and the ROM code storage live outside this block.

Top module: `search_step_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, step_busy_o, step_done_o and slot_req_o are 0 and step_status_o is 3'b000.
- R2: A start request sampled while idle produces a one-cycle slot_req_o with slot kind read (2'd2) after the next clock edge. The second read request follows the clock edge at which the first read's acknowledge is sampled. No other slot request is raised while a slot is outstanding.
- R3: The status fields are fixed: bit 0 is the first read value (id bit), bit 1 is the second read value (complement bit), and bit 2 is the branch taken.
- R4: If both reads return 1, the status is 3'b011 and no write slot is requested. step_done_o rises two clock edges after the second read's acknowledge is sampled, and step_busy_o falls at the same edge.
- R5: If both reads return 0, the branch equals the preferred branch sampled with the accepted start, and the status is 3'b100 for 1 or 3'b000 for 0.
- R6: If exactly one read returns 1, the branch equals the id bit, and the status is 3'b101 (id 1) or 3'b010 (id 0).
- R7: In every non-error case, a write slot request follows two clock edges after the second read's acknowledge. Its kind is 2'd1 to write 1 or 2'd0 to write 0, matching the branch. step_done_o rises at the edge that samples the write acknowledge.
- R8: step_done_o is a one-cycle pulse. step_status_o changes only together with step_done_o, and it holds its value through the following idle time and the next step up to that step's done pulse.
- R9: A start request while step_busy_o is high is ignored. It raises no extra slot request, and its preferred branch value does not affect the result.
- R10: A slot acknowledge while idle is ignored. It raises no request, no done pulse and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_start_i | input | 1 | Request to run one search step |
| pref_dir_i | input | 1 | Preferred branch used when both reads return 0 |
| step_busy_o | output | 1 | Step in progress |
| step_done_o | output | 1 | One-cycle pulse when the step ends |
| step_status_o | output | 3 | {branch, complement bit, id bit}; 3'b011 means no device |
| slot_req_o | output | 1 | One-cycle request to the slot engine |
| slot_kind_o | output | 2 | 0 write-0, 1 write-1, 2 read |
| slot_ack_i | input | 1 | One-cycle acknowledge from the slot engine |
| slot_bit_i | input | 1 | Bus level sampled by a read slot, valid with the acknowledge |

## Verification
The assertions assume the slot engine answers each request with exactly one single-cycle acknowledge. They also assume the read value is valid in that same cycle. The bench's engine model does both, after a chosen latency, and it never acknowledges twice. The one acknowledge sent with no request outstanding is sent while the unit is idle, which is the case R10 covers. Start requests are single-cycle pulses. The only start raised while busy is the one the R9 test sends on purpose, during a read latency.

// File: rtl/srch_pkg.sv
package srch_pkg;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned STAT_W = 3;

  typedef enum logic [KIND_W-1:0] {
    SLOT_WR0 = 2'd0,
    SLOT_WR1 = 2'd1,
    SLOT_RD  = 2'd2
  } slot_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_RD_CMP,
    ST_EVAL,
    ST_WR
  } seq_state_e;

  // field order is the caller's view of the status word
  typedef struct packed {
    logic dir;
    logic cmp;
    logic id;
  } step_stat_t;
endpackage

// File: rtl/srch_resolve.sv
module srch_resolve
  import srch_pkg::*;
(
  input  logic       id_i,
  input  logic       cmp_i,
  input  logic       pref_i,
  output logic       err_o,
  output logic       dir_o,
  output step_stat_t stat_o
);
  logic split;

  always_comb begin
    err_o  = id_i & cmp_i;
    split  = ~(id_i ^ cmp_i);
    dir_o  = err_o ? 1'b0 : (split ? pref_i : id_i);
    stat_o = '{dir: dir_o, cmp: cmp_i, id: id_i};
  end
endmodule

// File: rtl/srch_seq.sv
module srch_seq
  import srch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pref_i,
  input  logic              ack_i,
  input  logic              bit_i,
  input  logic              err_i,
  input  logic              dir_i,
  output logic              id_o,
  output logic              cmp_o,
  output logic              pref_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic              slot_req_o,
  output logic [KIND_W-1:0] slot_kind_o
);
  seq_state_e state_q;
  slot_kind_e kind_q;
  logic       req_q, id_q, cmp_q, pref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= SLOT_RD;
      req_q   <= 1'b0;
      id_q    <= 1'b0;
      cmp_q   <= 1'b0;
      pref_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pref_q  <= pref_i;
          req_q   <= 1'b1;
          kind_q  <= SLOT_RD;
          state_q <= ST_RD_ID;
        end
        ST_RD_ID: if (ack_i) begin
          id_q    <= bit_i;
          req_q   <= 1'b1;
          kind_q  <= SLOT_RD;
          state_q <= ST_RD_CMP;
        end
        ST_RD_CMP: if (ack_i) begin
          cmp_q   <= bit_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (err_i) begin
            state_q <= ST_IDLE;
          end else begin
            req_q   <= 1'b1;
            kind_q  <= dir_i ? SLOT_WR1 : SLOT_WR0;
            state_q <= ST_WR;
          end
        end
        ST_WR: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign id_o        = id_q;
  assign cmp_o       = cmp_q;
  assign pref_o      = pref_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign fin_o       = ((state_q == ST_EVAL) && err_i) || ((state_q == ST_WR) && ack_i);
  assign slot_req_o  = req_q;
  assign slot_kind_o = kind_q;

  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |=> !slot_req_o);
  // R9
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> busy_o);
  // R7
  kind_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> (slot_kind_o != 2'd3));
  // R4
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_EVAL) && err_i) |=> (!slot_req_o && !busy_o));
  // R10
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !slot_req_o);
endmodule

// File: rtl/srch_status.sv
module srch_status
  import srch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fin_i,
  input  step_stat_t        stat_i,
  output logic              done_o,
  output logic [STAT_W-1:0] stat_o
);
  logic              done_q;
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      stat_q <= '0;
    end else begin
      done_q <= fin_i;
      if (fin_i) stat_q <= stat_i;
    end
  end

  assign done_o = done_q;
  assign stat_o = stat_q;

  // R8
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_o) |-> done_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/search_step_unit.sv
module search_step_unit
  import srch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_start_i,
  input  logic              pref_dir_i,
  output logic              step_busy_o,
  output logic              step_done_o,
  output logic [STAT_W-1:0] step_status_o,
  output logic              slot_req_o,
  output logic [KIND_W-1:0] slot_kind_o,
  input  logic              slot_ack_i,
  input  logic              slot_bit_i
);
  logic       id_b, cmp_b, pref_b, err_b, dir_b, fin_b;
  step_stat_t stat_b;

  srch_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (step_start_i),
    .pref_i     (pref_dir_i),
    .ack_i      (slot_ack_i),
    .bit_i      (slot_bit_i),
    .err_i      (err_b),
    .dir_i      (dir_b),
    .id_o       (id_b),
    .cmp_o      (cmp_b),
    .pref_o     (pref_b),
    .busy_o     (step_busy_o),
    .fin_o      (fin_b),
    .slot_req_o (slot_req_o),
    .slot_kind_o(slot_kind_o)
  );

  srch_resolve i_resolve (
    .id_i  (id_b),
    .cmp_i (cmp_b),
    .pref_i(pref_b),
    .err_o (err_b),
    .dir_o (dir_b),
    .stat_o(stat_b)
  );

  srch_status i_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fin_i (fin_b),
    .stat_i(stat_b),
    .done_o(step_done_o),
    .stat_o(step_status_o)
  );

  // R3
  stat_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> (step_status_o inside {3'b000, 3'b100, 3'b101, 3'b010, 3'b011}));
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> !step_busy_o);
endmodule

// File: tb/test_search_step_unit.sv
module test_search_step_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pref = 1'b0;
  logic       ack = 1'b0;
  logic       sbit = 1'b0;
  logic       busy, done, req;
  logic [2:0] status;
  logic [1:0] kind;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  search_step_unit i_search_step_unit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .step_start_i (start),
    .pref_dir_i   (pref),
    .step_busy_o  (busy),
    .step_done_o  (done),
    .step_status_o(status),
    .slot_req_o   (req),
    .slot_kind_o  (kind),
    .slot_ack_i   (ack),
    .slot_bit_i   (sbit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // answer the outstanding request; returns at the negedge after the ack edge
  task automatic serve(input int exp_kind, input logic b, input int lat,
                       input logic poke, input logic poke_pref, input string tag);
    chk({tag, " R2 req"}, req, 1);
    chk({tag, " R7 kind"}, kind, exp_kind);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      if (poke && i == 0) begin
        start = 1'b1;
        pref  = poke_pref;
      end else begin
        start = 1'b0;
      end
      chk({tag, " R2 R9 no extra req"}, req, 0);
    end
    start = 1'b0;
    ack   = 1'b1;
    sbit  = b;
    @(negedge clk);
    ack  = 1'b0;
    sbit = 1'b0;
  endtask

  task automatic run_step(input logic p, input logic id, input logic cmp,
                          input int lat, input logic poke, input string tag);
    logic [2:0] exp;
    logic [2:0] prior;
    if (id && cmp)        exp = 3'b011;
    else if (!id && !cmp) exp = {p, 2'b00};
    else                  exp = id ? 3'b101 : 3'b010;
    prior = status;
    @(negedge clk);
    start = 1'b1;
    pref  = p;
    @(negedge clk);
    start = 1'b0;
    pref  = ~p;
    chk({tag, " R2 busy"}, busy, 1);
    serve(2, id, lat, poke, ~p, {tag, " rd_id"});
    chk({tag, " R8 held"}, status, prior);
    serve(2, cmp, lat, 1'b0, 1'b0, {tag, " rd_cmp"});
    chk({tag, " R2 busy"}, busy, 1);
    chk({tag, " R2 no req yet"}, req, 0);
    @(negedge clk);
    if (exp == 3'b011) begin
      chk({tag, " R4 done"}, done, 1);
      chk({tag, " R4 R3 status"}, status, exp);
      chk({tag, " R4 no write"}, req, 0);
      chk({tag, " R4 idle"}, busy, 0);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk({tag, " R4 no write later"}, req, 0);
        chk({tag, " R8 done pulse"}, done, 0);
      end
    end else begin
      chk({tag, " R7 no early done"}, done, 0);
      chk({tag, " R8 held"}, status, prior);
      serve(exp[2] ? 1 : 0, 1'b0, lat, 1'b0, 1'b0, {tag, " wr"});
      chk({tag, " R7 done"}, done, 1);
      chk({tag, " R3 R5 R6 status"}, status, exp);
      chk({tag, " R7 idle"}, busy, 0);
      @(negedge clk);
      chk({tag, " R8 done pulse"}, done, 0);
      chk({tag, " R8 status hold"}, status, exp);
      chk({tag, " R9 no restart"}, busy, 0);
    end
  endtask

  task automatic stray_ack();
    logic [2:0] prior;
    prior = status;
    @(negedge clk);
    ack  = 1'b1;
    sbit = 1'b1;
    @(negedge clk);
    ack  = 1'b0;
    sbit = 1'b0;
    chk("R10 no req", req, 0);
    chk("R10 no done", done, 0);
    chk("R10 idle", busy, 0);
    @(negedge clk);
    chk("R10 no req later", req, 0);
    chk("R10 status", status, prior);
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 req", req, 0);
    chk("R1 status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after", busy, 0);
    chk("R1 req after", req, 0);
    chk("R1 status after", status, 0);
  endtask

  initial begin
    reset_check();
    run_step(1'b1, 1'b0, 1'b1, 1, 1'b0, "R6 id0");
    run_step(1'b0, 1'b1, 1'b0, 2, 1'b0, "R6 id1");
    run_step(1'b1, 1'b0, 1'b0, 3, 1'b0, "R5 pref1");
    run_step(1'b0, 1'b0, 1'b0, 1, 1'b0, "R5 pref0");
    run_step(1'b1, 1'b1, 1'b1, 2, 1'b0, "R4 nodev");
    run_step(1'b0, 1'b0, 1'b0, 3, 1'b1, "R9 busy start");
    stray_ack();
    run_step(1'b1, 1'b1, 1'b0, 1, 1'b0, "R8 after stray");
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule